// File: doc/BRIEF.md
# Companded PCM Output Attenuator

This block sits in front of the PCM serializer of a multi-channel voice transcoder. Each channel delivers one 8-bit companded sample per 8 kHz frame. The block can forward that sample untouched, lower its level by 6 dB or 12 dB, or replace it with a silent idle code. To attenuate, it expands the code to a linear sign-magnitude value, shifts the magnitude right and compresses it again under the same law.

Each channel has its own frame sync, its own 2-bit gain control and its own code input. One law-select input is shared by all channels. On a rising edge of a channel's sync, the block captures that channel's code, control and law together. The processed result appears one clock later and is held for the whole frame, so that the serializer can shift it out at any rate.

Top module: `pcm_pad_atten`

## Requirements
- R1: After reset every channel outputs 0xFF, and the captured control of every channel is pass-through.
- R2: Control 00 sends the captured code to the output bit for bit.
- R3: Control 01 halves the linear magnitude, truncating toward zero, and re-encodes the result under the captured law. The sign bit (bit 7, where 1 means positive in both laws) is kept.
- R4: Control 10 quarters the linear magnitude, truncating toward zero, and re-encodes it under the captured law, with the sign kept.
- R5: Control 11 outputs the idle code, whatever the input code: 0xFF under µ-law and 0xD5 under A-law.
- R6: Law select 1 means A-law and 0 means µ-law. A-law codes carry even-bit inversion (XOR 0x55). µ-law codes are fully inverted, with a bias of 33 on a 13-bit magnitude. The law is captured with the sample and sets both expansion and compression.
- R7: Code, control and law are sampled only in the clock cycle where a channel's sync is seen high after being low. Changes at any other time do not alter the output, which holds its value until the next capture has been processed.
- R8: A capture made at clock edge E0 appears on the output after edge E0+1. Between E0 and E0+1 the output still shows the previous frame's result.
- R9: Channels are independent. A capture on one channel leaves the outputs of all other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| law_sel | input | 1 | 1 = A-law, 0 = µ-law, shared by all channels |
| frame_sync | input | NUM_CH | Per-channel frame sync; the rising edge triggers capture |
| pad_ctl | input | 2*NUM_CH | Per-channel gain control, channel n at bits [2n+1:2n] |
| pcm_in | input | 8*NUM_CH | Per-channel companded input code, channel n at bits [8n+7:8n] |
| pcm_out | output | 8*NUM_CH | Per-channel processed code, held for the frame |

## Verification
A corrupt capture register would show up as a wrong level, a wrong idle code or a wrong law on the next frame's output, one clock after the sync edge. A wrong edge detector would show up as an output that moves in mid-frame, while the inputs are being scrambled after capture. Faults in the expander or compressor show up under random codes as a code mismatch or a flipped sign, in the same cycle the frame result is loaded. Any crosstalk between lanes shows up as a change on an idle channel's output.

// File: rtl/pcm_pad_pkg.sv
package pcm_pad_pkg;

    localparam int CODE_W = 8;
    localparam int LIN_W  = 13;
    localparam int MU_BIAS = 33;
    localparam logic [CODE_W-1:0] MU_IDLE  = 8'hFF;
    localparam logic [CODE_W-1:0] A_IDLE   = 8'hD5;
    localparam logic [CODE_W-1:0] A_TOGGLE = 8'h55;

    typedef enum logic [1:0] {
        PAD_PASS = 2'b00,
        PAD_6DB  = 2'b01,
        PAD_12DB = 2'b10,
        PAD_IDLE = 2'b11
    } pad_mode_e;

    typedef struct packed {
        logic             neg;
        logic [LIN_W-1:0] mag;
    } lin_t;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        pad_mode_e         mode;
        logic              alaw;
    } frame_cap_t;

    function automatic lin_t mu_expand(input logic [CODE_W-1:0] code);
        logic [CODE_W-1:0] u;
        logic [LIN_W:0]    t;
        lin_t              r;
        u     = ~code;
        t     = ((LIN_W+1)'(u[3:0]) * (LIN_W+1)'(2) + (LIN_W+1)'(MU_BIAS)) << u[6:4];
        r.neg = u[7];
        r.mag = LIN_W'(t - (LIN_W+1)'(MU_BIAS));
        return r;
    endfunction

    function automatic logic [CODE_W-1:0] mu_compress(input lin_t x);
        logic [LIN_W:0] b;
        logic [2:0]     e;
        logic [3:0]     m;
        b = {1'b0, x.mag} + (LIN_W+1)'(MU_BIAS);
        e = 3'd0;
        for (int i = 0; i < 8; i++) begin
            if (b[5+i]) e = 3'(i);
        end
        m = 4'(b >> (int'(e) + 1));
        return ~{x.neg, e, m};
    endfunction

    function automatic lin_t a_expand(input logic [CODE_W-1:0] code);
        logic [CODE_W-1:0] x;
        logic [LIN_W-1:0]  base;
        lin_t              r;
        x     = code ^ A_TOGGLE;
        base  = LIN_W'({x[3:0], 1'b1});
        r.neg = ~x[7];
        if (x[6:4] == 3'd0) r.mag = base;
        else                r.mag = (base + LIN_W'(32)) << (x[6:4] - 3'd1);
        return r;
    endfunction

    function automatic logic [CODE_W-1:0] a_compress(input lin_t x);
        logic [2:0] e;
        logic [3:0] m;
        e = 3'd0;
        for (int i = 1; i < 8; i++) begin
            if (x.mag[4+i]) e = 3'(i);
        end
        if (e == 3'd0) m = x.mag[4:1];
        else           m = 4'(x.mag >> e);
        return {~x.neg, e, m} ^ A_TOGGLE;
    endfunction

    function automatic lin_t scale_down(input lin_t x, input logic [1:0] sh);
        lin_t r;
        r.neg = x.neg;
        r.mag = x.mag >> sh;
        return r;
    endfunction

endpackage

// File: rtl/pad_frame_capture.sv
module pad_frame_capture
    import pcm_pad_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_in,
    input  logic [CODE_W-1:0] code_in,
    input  logic [1:0]        mode_in,
    input  logic              alaw_in,
    output frame_cap_t        cap,
    output logic              load_q
);

    logic sync_q;
    logic sync_rise;

    assign sync_rise = sync_in & ~sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 1'b0;
            load_q <= 1'b0;
            cap    <= '{code: MU_IDLE, mode: PAD_PASS, alaw: 1'b0};
        end else begin
            sync_q <= sync_in;
            load_q <= sync_rise;
            if (sync_rise) begin
                cap.code <= code_in;
                cap.mode <= pad_mode_e'(mode_in);
                cap.alaw <= alaw_in;
            end
        end
    end

    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(sync_in && !sync_q) |=> $stable(cap)) else $error("capture moved off sync edge"); // R7

endmodule

// File: rtl/pad_gain_path.sv
module pad_gain_path
    import pcm_pad_pkg::*;
(
    input  frame_cap_t        cap,
    output logic [CODE_W-1:0] code_out
);

    lin_t              lin;
    lin_t              lin_sc;
    logic [1:0]        shift;
    logic [CODE_W-1:0] recoded;
    logic [CODE_W-1:0] idle_code;

    always_comb begin
        lin       = cap.alaw ? a_expand(cap.code) : mu_expand(cap.code);
        shift     = (cap.mode == PAD_12DB) ? 2'd2 : 2'd1;
        lin_sc    = scale_down(lin, shift);
        recoded   = cap.alaw ? a_compress(lin_sc) : mu_compress(lin_sc);
        idle_code = cap.alaw ? A_IDLE : MU_IDLE;
        unique case (cap.mode)
            PAD_PASS: code_out = cap.code;
            PAD_6DB,
            PAD_12DB: code_out = recoded;
            default:  code_out = idle_code;
        endcase
    end

endmodule

// File: rtl/pad_lane.sv
module pad_lane
    import pcm_pad_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              alaw_sel,
    input  logic              sync_in,
    input  logic [1:0]        mode_in,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] code_out
);

    frame_cap_t        cap;
    logic              load_q;
    logic [CODE_W-1:0] path_code;

    pad_frame_capture u_cap (
        .clk     (clk),
        .rst     (rst),
        .sync_in (sync_in),
        .code_in (code_in),
        .mode_in (mode_in),
        .alaw_in (alaw_sel),
        .cap     (cap),
        .load_q  (load_q)
    );

    pad_gain_path u_path (
        .cap      (cap),
        .code_out (path_code)
    );

    always_ff @(posedge clk) begin
        if (rst)         code_out <= MU_IDLE;
        else if (load_q) code_out <= path_code;
    end

    AST_OUT_STABLE: assert property (@(posedge clk) disable iff (rst)
        !load_q |=> $stable(code_out)) else $error("output moved mid-frame"); // R7

    AST_PASS_THRU: assert property (@(posedge clk) disable iff (rst)
        (load_q && cap.mode == PAD_PASS) |=> code_out == $past(cap.code)) else $error("pass-through altered"); // R2

    AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
        (load_q && (cap.mode == PAD_6DB || cap.mode == PAD_12DB)) |=> code_out[7] == $past(cap.code[7])) else $error("sign lost"); // R3

    AST_IDLE_CODE: assert property (@(posedge clk) disable iff (rst)
        (load_q && cap.mode == PAD_IDLE) |=> (code_out == MU_IDLE || code_out == A_IDLE)) else $error("bad idle code"); // R5

endmodule

// File: rtl/pcm_pad_atten.sv
module pcm_pad_atten
    import pcm_pad_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     law_sel,
    input  logic [NUM_CH-1:0]        frame_sync,
    input  logic [2*NUM_CH-1:0]      pad_ctl,
    input  logic [CODE_W*NUM_CH-1:0] pcm_in,
    output logic [CODE_W*NUM_CH-1:0] pcm_out
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        pad_lane u_lane (
            .clk      (clk),
            .rst      (rst),
            .alaw_sel (law_sel),
            .sync_in  (frame_sync[g]),
            .mode_in  (pad_ctl[2*g +: 2]),
            .code_in  (pcm_in[CODE_W*g +: CODE_W]),
            .code_out (pcm_out[CODE_W*g +: CODE_W])
        );
    end

endmodule

// File: tb/sim_pcm_pad_atten.sv
module sim_pcm_pad_atten;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           law_sel = 1'b0;
    logic [NCH-1:0] frame_sync = '0;
    logic [2*NCH-1:0] pad_ctl = '0;
    logic [8*NCH-1:0] pcm_in = '0;
    logic [8*NCH-1:0] pcm_out;

    int checks = 0;
    int errors = 0;
    logic [7:0] expect_q [NCH];

    pcm_pad_atten #(.NUM_CH(NCH)) u0 (
        .clk        (clk),
        .rst        (rst),
        .law_sel    (law_sel),
        .frame_sync (frame_sync),
        .pad_ctl    (pad_ctl),
        .pcm_in     (pcm_in),
        .pcm_out    (pcm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] ref_code(logic [7:0] code, logic [1:0] ctl, logic alaw);
        logic [7:0] u;
        logic       sgn;
        int         e0, m0, mag, b, e, m;
        if (ctl == 2'b00) return code;
        if (ctl == 2'b11) return alaw ? 8'hD5 : 8'hFF;
        if (!alaw) begin
            u   = ~code;
            sgn = u[7];
            e0  = int'(u[6:4]);
            m0  = int'(u[3:0]);
            mag = ((m0 * 2 + 33) << e0) - 33;
            mag = mag >> int'(ctl);
            b   = mag + 33;
            e   = 0;
            while (e < 7 && b >= (64 << e)) e++;
            m   = (b >> (e + 1)) - 16;
            return ~{sgn, 3'(e), 4'(m)};
        end else begin
            u   = code ^ 8'h55;
            sgn = u[7];
            e0  = int'(u[6:4]);
            m0  = int'(u[3:0]);
            mag = (e0 == 0) ? (m0 * 2 + 1) : ((m0 * 2 + 33) << (e0 - 1));
            mag = mag >> int'(ctl);
            e   = 0;
            while (e < 7 && mag >= (32 << e)) e++;
            m   = (e == 0) ? (mag >> 1) : ((mag >> e) - 16);
            return {sgn, 3'(e), 4'(m)} ^ 8'h55;
        end
    endfunction

    function automatic string mode_tag(logic [1:0] ctl);
        case (ctl)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, act, expv);
        end
    endtask

    task automatic check_others(int ch);
        for (int k = 0; k < NCH; k++)
            if (k != ch) check("R9", pcm_out[8*k +: 8], expect_q[k]);
    endtask

    task automatic run_frame(int ch, logic [7:0] code, logic [1:0] ctl, logic alaw);
        logic [7:0] want;
        @(negedge clk);
        law_sel = alaw;
        pcm_in[8*ch +: 8]  = code;
        pad_ctl[2*ch +: 2] = ctl;
        frame_sync[ch]     = 1'b1;
        @(negedge clk);
        check("R8", pcm_out[8*ch +: 8], expect_q[ch]);
        frame_sync[ch]     = 1'b0;
        pcm_in[8*ch +: 8]  = 8'($urandom);
        pad_ctl[2*ch +: 2] = 2'($urandom);
        law_sel            = ~alaw;
        @(negedge clk);
        want = ref_code(code, ctl, alaw);
        check(alaw ? "R6" : mode_tag(ctl), pcm_out[8*ch +: 8], want);
        expect_q[ch] = want;
        repeat (3) @(negedge clk);
        check("R7", pcm_out[8*ch +: 8], want);
        check_others(ch);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: got hang expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int k = 0; k < NCH; k++) expect_q[k] = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int k = 0; k < NCH; k++) check("R1", pcm_out[8*k +: 8], 8'hFF);

        // R1: captured control after reset is pass-through; a fresh frame with 00 passes
        run_frame(0, 8'h3C, 2'b00, 1'b0);
        // R3 directed: µ-law positive zero stays, full scale halves
        run_frame(1, 8'hFF, 2'b01, 1'b0);
        run_frame(1, 8'h80, 2'b01, 1'b0);
        run_frame(1, 8'h00, 2'b10, 1'b0);
        // R4 / R6 directed: A-law extremes
        run_frame(2, 8'hAA, 2'b10, 1'b1);
        run_frame(2, 8'h2A, 2'b01, 1'b1);
        run_frame(2, 8'hD5, 2'b10, 1'b1);
        run_frame(2, 8'h55, 2'b01, 1'b1);
        // R5: idle under both laws
        run_frame(3, 8'h12, 2'b11, 1'b0);
        run_frame(3, 8'h12, 2'b11, 1'b1);
        run_frame(3, 8'h9A, 2'b00, 1'b1);

        // R7: sync held high keeps one capture only
        @(negedge clk);
        pcm_in[7:0] = 8'hA0; pad_ctl[1:0] = 2'b00; law_sel = 1'b0; frame_sync[0] = 1'b1;
        repeat (2) @(negedge clk);
        check("R7", pcm_out[7:0], 8'hA0);
        pcm_in[7:0] = 8'h11; pad_ctl[1:0] = 2'b11;
        repeat (3) @(negedge clk);
        check("R7", pcm_out[7:0], 8'hA0);
        frame_sync[0] = 1'b0;
        expect_q[0] = 8'hA0;
        repeat (2) @(negedge clk);

        // R9: all channels at once with distinct controls
        @(negedge clk);
        law_sel = 1'b0;
        for (int k = 0; k < NCH; k++) begin
            pcm_in[8*k +: 8]  = 8'h90 + 8'(k * 7);
            pad_ctl[2*k +: 2] = 2'(k);
        end
        frame_sync = '1;
        repeat (2) @(negedge clk);
        frame_sync = '0;
        for (int k = 0; k < NCH; k++) begin
            expect_q[k] = ref_code(8'h90 + 8'(k * 7), 2'(k), 1'b0);
            check("R9", pcm_out[8*k +: 8], expect_q[k]);
        end

        // random frames
        for (int n = 0; n < 400; n++)
            run_frame(int'($urandom_range(NCH-1)), 8'($urandom), 2'($urandom), 1'($urandom));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule